// File: doc/BRIEF.md
# E1 Timeslot-16 Multiframe AIS Detector

This block watches the signalling channel (timeslot 16) of an E1 receive stream and raises a real-time alarm level when that channel carries an all-ones alarm indication signal across whole multiframes. An upstream framer supplies the receive bit, a strobe marking timeslot-16 bits, and a strobe marking the first cycle of each multiframe. In a normal multiframe the strobe marks 128 channel bits (16 frames of 8 bits). The block counts the zeros seen on the channel during each multiframe. At each boundary it judges the multiframe that just ended. The alarm is declared once enough consecutive multiframes have been nearly all ones.

Detection only runs while channel-associated signalling mode is on. Turning that mode off drops the alarm and clears the history, and the first, partial multiframe after the mode is turned on is not judged. Besides the alarm level, the block gives a one-cycle change pulse for interrupt logic. It also gives the zero count of the last judged multiframe for debug.

Top module: `e1_mf_ais_monitor`

## Requirements
- R1: Only bits marked by `ts16_en` are counted; zeros on unmarked cycles have no effect on the count or the alarm.
- R2: At each judged boundary `last_zero_cnt` takes the zero count of the multiframe just ended, saturated at 4 (4 means four or more). A multiframe qualifies when that count is 3 or less. `last_zero_cnt` changes at no other time.
- R3: `ais_status` goes high in the cycle after the boundary strobe that closes the second consecutive qualifying multiframe.
- R4: A single qualifying multiframe followed by a non-qualifying one leaves `ais_status` low.
- R5: `ais_status` goes low in the cycle after the boundary strobe that closes the first multiframe with four or more zeros.
- R6: While `cas_on` is low, `ais_status` is low from the next cycle on, counting stops, and the history of qualifying multiframes is cleared. After re-enable, two fresh qualifying multiframes are needed again. `last_zero_cnt` holds its value.
- R7: After `cas_on` rises, the first boundary strobe only starts counting. The partial multiframe before it is not judged.
- R8: `ais_change` is high for exactly the cycles in which `ais_status` differs from its value in the previous cycle, and low otherwise.
- R9: After reset, `ais_status`, `ais_change` and `last_zero_cnt` are all 0.
- R10: A marked channel bit on the same cycle as the boundary strobe belongs to the new multiframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial receive data bit |
| ts16_en | input | 1 | High when `rx_bit` is a timeslot-16 bit |
| mf_mark | input | 1 | One-cycle strobe on the first cycle of each multiframe |
| cas_on | input | 1 | Signalling-multiframe mode enable; detection runs only while high |
| ais_status | output | 1 | Real-time multiframe AIS alarm level |
| ais_change | output | 1 | One-cycle pulse on each alarm transition |
| last_zero_cnt | output | 3 | Saturated zero count of the last judged multiframe |

## Verification
The assertions assume that the inputs are synchronous to `clk`. They also assume that `mf_mark` is a single-cycle strobe separated by full multiframes, though nothing in the checks depends on the exact spacing. The bench drives every input at the falling edge and sends multiframes of 128 marked bits, each followed by an unmarked cycle that carries a zero. This keeps the strobes well formed while stressing the counter's gating. The rise and fall properties tie each alarm edge to a qualifying cause, either an enabled boundary or a dropped mode enable. The bench covers the one case that needs a mode change in mid multiframe: it drops and raises `cas_on` away from a boundary strobe.

// File: rtl/e1ais_pkg.sv
package e1ais_pkg;

  // Arming state of the multiframe judge
  typedef enum logic [1:0] {
    ARM_OFF  = 2'd0,  // signalling mode off, nothing judged
    ARM_WAIT = 2'd1,  // mode on, waiting for first boundary
    ARM_LIVE = 2'd2   // boundaries close complete multiframes
  } arm_e;

  // Count width able to hold 0..limit+1
  function automatic int tally_width(input int zero_limit);
    return $clog2(zero_limit + 2);
  endfunction

endpackage

// File: rtl/e1ais_zero_tally.sv
module e1ais_zero_tally #(
  parameter int SAT_MAX = 4,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          bit_vld,
  input  logic          bit_val,
  input  logic          mf_mark,
  output logic [CW-1:0] tally
);

  localparam logic [CW-1:0] SAT_V = CW'(SAT_MAX);

  logic hit;
  assign hit = bit_vld && !bit_val;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      tally <= '0;
    end else if (mf_mark) begin
      // a marked bit on the boundary cycle opens the new multiframe
      tally <= hit ? CW'(1) : '0;
    end else if (hit && tally != SAT_V) begin
      tally <= tally + CW'(1);
    end
  end

endmodule

// File: rtl/e1ais_mf_judge.sv
module e1ais_mf_judge
  import e1ais_pkg::*;
#(
  parameter int ZERO_LIMIT = 3,
  parameter int CONFIRM    = 2,
  parameter int CW         = 3,
  parameter int RW         = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          mf_mark,
  input  logic [CW-1:0] tally,
  input  logic          status_q,
  output logic          status_next,
  output logic [CW-1:0] last_cnt
);

  localparam logic [CW-1:0] LIM_V = CW'(ZERO_LIMIT);
  localparam logic [RW-1:0] CNF_V = RW'(CONFIRM);

  arm_e          arm;
  logic [RW-1:0] run;
  logic [RW-1:0] run_inc;
  logic          eval;
  logic          qual;

  assign eval    = enable && mf_mark && (arm == ARM_LIVE);
  assign qual    = (tally <= LIM_V);
  assign run_inc = (run == CNF_V) ? run : run + RW'(1);

  always_comb begin
    status_next = status_q;
    if (!enable) begin
      status_next = 1'b0;
    end else if (eval) begin
      if (!qual)
        status_next = 1'b0;
      else if (run_inc >= CNF_V)
        status_next = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      arm <= ARM_OFF;
    end else begin
      unique case (arm)
        ARM_OFF:  arm <= mf_mark ? ARM_LIVE : ARM_WAIT;
        ARM_WAIT: if (mf_mark) arm <= ARM_LIVE;
        default:  arm <= ARM_LIVE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      run <= '0;
    end else if (eval) begin
      run <= qual ? run_inc : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cnt <= '0;
    end else if (eval) begin
      last_cnt <= tally;
    end
  end

endmodule

// File: rtl/e1ais_level_edge.sv
module e1ais_level_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl_next,
  output logic lvl_q,
  output logic chg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      lvl_q <= lvl_next;
      chg_q <= (lvl_next != lvl_q);
    end
  end

endmodule

// File: rtl/e1_mf_ais_monitor.sv
module e1_mf_ais_monitor
  import e1ais_pkg::*;
#(
  parameter int ZERO_LIMIT = 3,
  parameter int CONFIRM    = 2,
  parameter int CNT_W      = tally_width(ZERO_LIMIT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  input  logic             ts16_en,
  input  logic             mf_mark,
  input  logic             cas_on,
  output logic             ais_status,
  output logic             ais_change,
  output logic [CNT_W-1:0] last_zero_cnt
);

  localparam int SAT_MAX = ZERO_LIMIT + 1;
  localparam int RUN_W   = $clog2(CONFIRM + 1);

  logic [CNT_W-1:0] tally;
  logic             status_next;

  e1ais_zero_tally #(
    .SAT_MAX (SAT_MAX),
    .CW      (CNT_W)
  ) u_tally (
    .clk     (clk),
    .rst     (rst),
    .enable  (cas_on),
    .bit_vld (ts16_en),
    .bit_val (rx_bit),
    .mf_mark (mf_mark),
    .tally   (tally)
  );

  e1ais_mf_judge #(
    .ZERO_LIMIT (ZERO_LIMIT),
    .CONFIRM    (CONFIRM),
    .CW         (CNT_W),
    .RW         (RUN_W)
  ) u_judge (
    .clk         (clk),
    .rst         (rst),
    .enable      (cas_on),
    .mf_mark     (mf_mark),
    .tally       (tally),
    .status_q    (ais_status),
    .status_next (status_next),
    .last_cnt    (last_zero_cnt)
  );

  e1ais_level_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .lvl_next (status_next),
    .lvl_q    (ais_status),
    .chg_q    (ais_change)
  );

endmodule

// File: rtl/e1ais_checker.sv
module e1ais_checker #(
  parameter int CW      = 3,
  parameter int SAT_MAX = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mf_mark,
  input logic          cas_on,
  input logic          ais_status,
  input logic          ais_change,
  input logic [CW-1:0] last_zero_cnt
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_cas_off_clears_R6: assert property (@(posedge clk) disable iff (rst)
    !cas_on |=> !ais_status);

  assert_change_tracks_level_R8: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (ais_change == (ais_status != $past(ais_status))));

  assert_rise_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $rose(ais_status)) |-> $past(mf_mark && cas_on));

  assert_fall_has_cause_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $fell(ais_status)) |-> $past(mf_mark || !cas_on));

  assert_count_saturates_R2: assert property (@(posedge clk) disable iff (rst)
    last_zero_cnt <= CW'(SAT_MAX));

  assert_count_held_between_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(mf_mark && cas_on)) |-> $stable(last_zero_cnt));

endmodule

bind e1_mf_ais_monitor e1ais_checker #(
  .CW      (CNT_W),
  .SAT_MAX (ZERO_LIMIT + 1)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mf_mark       (mf_mark),
  .cas_on        (cas_on),
  .ais_status    (ais_status),
  .ais_change    (ais_change),
  .last_zero_cnt (last_zero_cnt)
);

// File: tb/e1_mf_ais_monitor_tb.sv
module e1_mf_ais_monitor_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1;
  logic       ts16_en = 1'b0;
  logic       mf_mark = 1'b0;
  logic       cas_on = 1'b0;
  logic       ais_status;
  logic       ais_change;
  logic [2:0] last_zero_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_mf_ais_monitor u_dut (
    .clk           (clk),
    .rst           (rst),
    .rx_bit        (rx_bit),
    .ts16_en       (ts16_en),
    .mf_mark       (mf_mark),
    .cas_on        (cas_on),
    .ais_status    (ais_status),
    .ais_change    (ais_change),
    .last_zero_cnt (last_zero_cnt)
  );

  typedef struct {
    logic  st;
    logic  chg;
    int    last;
    string req;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   chk_idle = 0;
  bit   done = 0;

  // reference model state
  bit m_armed = 0;
  int m_run   = 0;
  bit m_st    = 0;
  int m_cnt   = 0;
  int m_last  = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(bit mk, bit ts, bit b);
    @(negedge clk);
    mf_mark = mk;
    ts16_en = ts;
    rx_bit  = b;
  endtask

  // expectation for the boundary about to be driven
  task automatic model_mark(string req);
    bit q;
    bit ns;
    if (!m_armed) begin
      m_armed = 1;
      sb_q.push_back('{m_st, 1'b0, m_last, "R7"});
    end else begin
      q     = (m_cnt <= 3);
      m_run = q ? ((m_run < 2) ? m_run + 1 : 2) : 0;
      ns    = q ? ((m_run >= 2) ? 1'b1 : m_st) : 1'b0;
      m_last = m_cnt;
      sb_q.push_back('{ns, logic'(ns != m_st), m_last, req});
      m_st = ns;
    end
  endtask

  // one multiframe of 128 channel bits, each followed by an unmarked zero (R1)
  task automatic send_mf(int zeros, bit tail, string req);
    model_mark(req);
    m_cnt = (zeros > 4) ? 4 : zeros;
    for (int i = 0; i < 128; i++) begin
      bit z;
      z = tail ? (i >= 128 - zeros) : (i < zeros);
      tick(i == 0, 1'b1, !z);
      tick(1'b0, 1'b0, 1'b0);
    end
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      if (mf_mark && cas_on) begin
        if (sb_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R8 actual=unexpected boundary expected=queued item");
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({e.req, " status"}, ais_status, e.st);
          check({e.req, " R8 change"}, ais_change, e.chg);
          check({e.req, " R2 last"}, last_zero_cnt, e.last);
        end
      end else if (chk_idle) begin
        check("R8 idle change", ais_change, 0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R9 status", ais_status, 0);
    check("R9 change", ais_change, 0);
    check("R9 last", last_zero_cnt, 0);

    // enable mid multiframe: partial all-ones stretch must not be judged
    tick(1'b0, 1'b0, 1'b1);
    cas_on = 1'b1;
    chk_idle = 1;
    for (int i = 0; i < 40; i++) tick(1'b0, 1'b1, 1'b1);

    send_mf(0, 0, "R7");       // first boundary: no judgement
    send_mf(3, 1, "R1");       // judge A=0 (junk zeros ignored)
    send_mf(4, 0, "R3");       // judge B=3 -> alarm rises
    send_mf(1, 0, "R5/R10");   // judge C=4 (zero on boundary counted) -> falls
    send_mf(6, 0, "R4");       // judge D=1 -> one qualifying
    send_mf(0, 0, "R4");       // judge E=6 -> stays low, last saturates at 4
    send_mf(2, 0, "R3");       // judge F=0
    send_mf(0, 0, "R3");       // judge G=2 -> alarm rises
    for (int i = 0; i < 30; i++) tick(1'b0, 1'b1, 1'b1);

    // drop signalling mode mid multiframe
    chk_idle = 0;
    @(negedge clk);
    cas_on = 1'b0;
    @(posedge clk); #1;
    check("R6 status off", ais_status, 0);
    check("R8 change on drop", ais_change, 1);
    check("R6 last held", last_zero_cnt, m_last);
    @(posedge clk); #1;
    check("R8 change one cycle", ais_change, 0);
    for (int i = 0; i < 20; i++) tick(i == 5, 1'b1, 1'b0);
    @(posedge clk); #1;
    check("R6 status stays low", ais_status, 0);
    check("R6 last held off", last_zero_cnt, m_last);
    m_armed = 0;
    m_run   = 0;
    m_st    = 0;

    // re-enable mid multiframe: history must start over
    tick(1'b0, 1'b0, 1'b1);
    cas_on = 1'b1;
    chk_idle = 1;
    for (int i = 0; i < 25; i++) tick(1'b0, 1'b1, 1'b1);
    send_mf(0, 0, "R7");       // first boundary after enable
    send_mf(0, 0, "R6");       // judge I=0 -> only one, stays low
    model_mark("R3");          // judge J=0 -> rises
    tick(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b1);
    @(posedge clk); #1;
    check("R3 final level", ais_status, 1);
    check("R8 scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule